// File: doc/BRIEF.md
# Sample Rate Ratio Estimator with Hysteresis

This block estimates how fast the incoming sample stream runs compared with the outgoing one. It watches two strobes that are already synchronized to its clock, one pulse per input sample and one pulse per output sample. A measurement window is a fixed run of input strobes. The block counts the output strobes that arrive while one window is open. When the window closes, that count becomes a fixed-point ratio, input rate over output rate. A downstream resampling filter uses this ratio to lengthen its impulse response and to scale its coefficient stepping when it decimates.

If output strobes arrive at least as often as input strobes, no decimation is needed, so the reported ratio is pinned at exactly one. If the input is faster, a new measurement replaces the reported ratio only when its output count differs from the count behind the current ratio by more than a small margin. This stops the filter length from flipping back and forth when the measurement jitters by a strobe or two. Each change of the reported value comes with a one-cycle update pulse.

Top module: `srr_ratio_est`

## Requirements
- R1: While reset is active and after it is released, `ratio` reads 0x1000 (1.0 in unsigned Q4.12) and `ratio_upd` is low. Reset clears the partial window and the output-strobe count.
- R2: A window closes on the cycle that carries the 256th input strobe since reset or since the previous window closed. The result of that window appears on `ratio` and `ratio_upd` one clock later. At no other time does `ratio` change or `ratio_upd` go high.
- R3: The count for a window includes every cycle with `out_stb` high during the window, including the closing cycle and cycles where both strobes are high. The count saturates at 256.
- R4: A window count of 256 or more makes the measured ratio exactly 0x1000. It is always accepted, and it resets the hysteresis reference to 256.
- R5: A window count N below 256 gives a measured ratio of floor(1048576 / N), limited to 0xFFFF. A count of 0 gives 0xFFFF.
- R6: A measurement from R5 is accepted only if N differs from the hysteresis reference by more than 2. Accepting it sets the reference to N. The reference is 256 after reset. A rejected measurement leaves `ratio` unchanged.
- R7: `ratio_upd` is high for exactly one cycle, in the cycle where `ratio` takes a value different from its previous one. An accepted measurement equal to the current ratio produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | One-cycle pulse per input sample |
| out_stb | input | 1 | One-cycle pulse per output sample |
| ratio | output | 16 | Reported input/output rate ratio, unsigned Q4.12 |
| ratio_upd | output | 1 | One-cycle pulse when `ratio` changes |

## Verification
The hardest situations to reach are the hysteresis edges. These need a window count exactly 2 and exactly 3 away from a reference that was itself set by an earlier accepted window. They also need accepted windows whose saturated result equals the current ratio, so that no pulse may appear. The bench places an exact number of output strobes in each window, either before the input strobes or coinciding with them. It chains windows so that each one builds the reference the next one tests against. Pushing more than 511 output strobes into one window exposes counter wrap, and a reset in mid-window exposes any leftover partial count.

// File: rtl/srr_pkg.sv
package srr_pkg;

  // Measured ratio, rounded down: (2^(win_log2+frac)) / cnt,
  // pinned to 1.0 when cnt >= window, saturated to full scale.
  function automatic int unsigned srr_quot(int unsigned cnt, int unsigned win_log2,
                                           int unsigned frac, int unsigned rw);
    longint unsigned num;
    longint unsigned maxv;
    longint unsigned q;
    num  = 64'd1 << (win_log2 + frac);
    maxv = (64'd1 << rw) - 64'd1;
    if (cnt >= (32'd1 << win_log2)) return 32'd1 << frac;
    if (cnt == 32'd0) return 32'(maxv);
    q = num / 64'(cnt);
    return (q > maxv) ? 32'(maxv) : 32'(q);
  endfunction

  function automatic int unsigned srr_absdiff(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/srr_strobe_window.sv
module srr_strobe_window #(
  parameter int WIN_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic              out_stb,
  output logic              win_done,
  output logic [WIN_LOG2:0] win_cnt
);
  localparam int WIN = 1 << WIN_LOG2;
  localparam int CW  = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0] in_cnt_q;
  logic [CW-1:0]       out_cnt_q;
  logic [CW-1:0]       out_sum;

  assign out_sum  = (out_stb && (out_cnt_q != CW'(WIN))) ? out_cnt_q + 1'b1 : out_cnt_q;
  assign win_done = in_stb && (in_cnt_q == {WIN_LOG2{1'b1}});
  assign win_cnt  = out_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else if (win_done) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else begin
      if (in_stb) in_cnt_q <= in_cnt_q + 1'b1;
      out_cnt_q <= out_sum;
    end
  end

  AST_OUT_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt_q <= CW'(WIN)); // R3
  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> (in_cnt_q == '0) && (out_cnt_q == '0)); // R2
endmodule

// File: rtl/srr_ratio_calc.sv
module srr_ratio_calc
  import srr_pkg::*;
#(
  parameter int WIN_LOG2 = 8,
  parameter int FRAC     = 12,
  parameter int RW       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_LOG2:0] win_cnt,
  output logic [RW-1:0]     cand,
  output logic              clamp
);
  localparam int WIN = 1 << WIN_LOG2;

  assign clamp = (32'(win_cnt) >= 32'(WIN));
  assign cand  = RW'(srr_quot(32'(win_cnt), WIN_LOG2, FRAC, RW));

  AST_CLAMP_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> (cand == RW'(1 << FRAC))); // R4
  AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == '0) |-> (cand == {RW{1'b1}})); // R5
endmodule

// File: rtl/srr_hyst_reg.sv
module srr_hyst_reg
  import srr_pkg::*;
#(
  parameter int WIN_LOG2 = 8,
  parameter int FRAC     = 12,
  parameter int RW       = 16,
  parameter int HYST     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_done,
  input  logic [WIN_LOG2:0] win_cnt,
  input  logic [RW-1:0]     cand,
  input  logic              clamp,
  output logic [RW-1:0]     ratio,
  output logic              ratio_upd
);
  localparam int          WIN = 1 << WIN_LOG2;
  localparam int          CW  = WIN_LOG2 + 1;
  localparam logic [RW-1:0] ONE = RW'(1 << FRAC);

  logic [CW-1:0] ref_q;
  logic [RW-1:0] ratio_q;
  logic          upd_q;
  logic          near_ref;
  logic          accept;

  assign near_ref = srr_absdiff(32'(win_cnt), 32'(ref_q)) <= 32'(HYST);
  assign accept   = win_done && (clamp || !near_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= CW'(WIN);
      ratio_q <= ONE;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (accept) begin
        ref_q   <= clamp ? CW'(WIN) : win_cnt;
        ratio_q <= cand;
        upd_q   <= (cand != ratio_q);
      end
    end
  end

  assign ratio     = ratio_q;
  assign ratio_upd = upd_q;

  AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_upd |-> (ratio != $past(ratio))); // R7
  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_upd |-> $stable(ratio)); // R7
  AST_UPD_ONLY_AT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_upd |-> $past(win_done)); // R2
  AST_CLAMP_GIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && clamp) |=> (ratio == ONE)); // R4
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !clamp && near_ref) |=> ($stable(ratio) && !ratio_upd)); // R6
endmodule

// File: rtl/srr_ratio_est.sv
module srr_ratio_est #(
  parameter int WIN_LOG2 = 8,
  parameter int INT_BITS = 4,
  parameter int FRAC     = 12,
  parameter int HYST     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_stb,
  input  logic                     out_stb,
  output logic [INT_BITS+FRAC-1:0] ratio,
  output logic                     ratio_upd
);
  localparam int RW = INT_BITS + FRAC;

  logic              win_done;
  logic [WIN_LOG2:0] win_cnt;
  logic [RW-1:0]     cand;
  logic              clamp;

  srr_strobe_window #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .out_stb(out_stb),
    .win_done(win_done), .win_cnt(win_cnt)
  );

  srr_ratio_calc #(.WIN_LOG2(WIN_LOG2), .FRAC(FRAC), .RW(RW)) u_calc (
    .clk(clk), .rst_n(rst_n), .win_cnt(win_cnt), .cand(cand), .clamp(clamp)
  );

  srr_hyst_reg #(.WIN_LOG2(WIN_LOG2), .FRAC(FRAC), .RW(RW), .HYST(HYST)) u_hyst (
    .clk(clk), .rst_n(rst_n), .win_done(win_done), .win_cnt(win_cnt),
    .cand(cand), .clamp(clamp), .ratio(ratio), .ratio_upd(ratio_upd)
  );

  AST_RESET_VALUE: assert property (@(posedge clk)
    $past(!rst_n) |-> (ratio == RW'(1 << FRAC)) && !ratio_upd); // R1
endmodule

// File: tb/tb_srr_ratio_est.sv
module tb_srr_ratio_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_stb = 1'b0;
  logic        out_stb = 1'b0;
  logic [15:0] ratio;
  logic        ratio_upd;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  srr_ratio_est dut (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .out_stb(out_stb),
    .ratio(ratio), .ratio_upd(ratio_upd)
  );

  // {n_out[27:18], overlap[17], exp_ratio[16:1], exp_upd[0]}
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {10'd300, 1'b0, 16'd4096,  1'b0},  // R4 clamp, already 1.0
    {10'd254, 1'b0, 16'd4096,  1'b0},  // R6 diff 2 rejected
    {10'd253, 1'b0, 16'd4144,  1'b1},  // R6 diff 3 accepted, R5
    {10'd255, 1'b0, 16'd4144,  1'b0},  // R6
    {10'd250, 1'b0, 16'd4194,  1'b1},  // R5
    {10'd128, 1'b1, 16'd8192,  1'b1},  // R3 coincident strobes
    {10'd130, 1'b1, 16'd8192,  1'b0},  // R6
    {10'd126, 1'b0, 16'd8192,  1'b0},  // R6
    {10'd125, 1'b0, 16'd8388,  1'b1},  // R5
    {10'd256, 1'b1, 16'd4096,  1'b1},  // R4 exactly 256
    {10'd64,  1'b1, 16'd16384, 1'b1},  // R5
    {10'd16,  1'b0, 16'd65535, 1'b1},  // R5 saturate
    {10'd0,   1'b0, 16'd65535, 1'b0},  // R5 zero, R7 no pulse
    {10'd2,   1'b0, 16'd65535, 1'b0},  // R6
    {10'd3,   1'b0, 16'd65535, 1'b0},  // R7 accepted, same value
    {10'd200, 1'b0, 16'd5242,  1'b1}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one window; returns pulses seen and count of mid-window ratio changes.
  task automatic run_window(input int n, input bit ov, output int pulses, output int moves);
    logic [15:0] start;
    int cyc;
    start  = ratio;
    pulses = 0;
    moves  = 0;
    cyc    = ov ? 256 : n + 256;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (ratio_upd) pulses++;
      if (ratio != start) moves++;
      if (ov) begin
        in_stb  = 1'b1;
        out_stb = (k < n);
      end else begin
        in_stb  = (k >= n);
        out_stb = (k < n);
      end
    end
    @(negedge clk);
    in_stb  = 1'b0;
    out_stb = 1'b0;
    if (ratio_upd) pulses++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    int moves;
    repeat (3) @(negedge clk);
    check(ratio == 16'h1000, "R1 reset ratio", ratio, 4096);
    check(ratio_upd == 1'b0, "R1 reset upd", ratio_upd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ratio == 16'h1000, "R1 after release", ratio, 4096);

    for (int i = 0; i < NV; i++) begin
      run_window(int'(VEC[i][27:18]), VEC[i][17], pulses, moves);
      check(ratio == VEC[i][16:1], $sformatf("R5/R6 ratio vec %0d", i),
            ratio, int'(VEC[i][16:1]));
      check(pulses == int'(VEC[i][0]), $sformatf("R7 pulse vec %0d", i),
            pulses, int'(VEC[i][0]));
      check(moves == 0, $sformatf("R2 mid-window hold vec %0d", i), moves, 0);
      @(negedge clk);
      check(ratio_upd == 1'b0, $sformatf("R7 single cycle vec %0d", i), ratio_upd, 0);
    end

    // R3: counter must saturate, not wrap, beyond 511 strobes
    run_window(520, 1'b0, pulses, moves);
    check(ratio == 16'h1000, "R3 saturation", ratio, 4096);
    check(pulses == 1, "R3 R4 pulse", pulses, 1);

    // R1: reset in mid-window discards partial counts
    run_window(64, 1'b1, pulses, moves);
    check(ratio == 16'd16384, "R5 before reset", ratio, 16384);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      in_stb  = 1'b1;
      out_stb = 1'b1;
    end
    @(negedge clk);
    in_stb  = 1'b0;
    out_stb = 1'b0;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    check(ratio == 16'h1000, "R1 reset mid-run", ratio, 4096);
    rst_n = 1'b1;
    run_window(128, 1'b1, pulses, moves);
    check(ratio == 16'd8192, "R1 counters cleared", ratio, 8192);
    check(moves == 0, "R2 first window hold", moves, 0);
    check(pulses == 1, "R7 first window pulse", pulses, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule